// File: doc/BRIEF.md
# Charge-Enable Pulse Modulator

This block turns the charge phase that the controller has chosen into the waveform for an open-drain charge-enable pin. When the pin is released (high impedance), the external supply may push current into the battery. When the pin is pulled low, that current is blocked.

During fast charge the pin stays released. During top-off the pin is released for a short fixed burst at the start of every period. During pulse-trickle it is released for a burst whose length follows the selected charge-rate mode, so that the average trickle current stays about the same for every rate. In low-power mode the pin floats. In the off state it is held low.

The block counts time in ticks of an external one-millisecond strobe. Top-off and trickle share one period counter. Any change of phase restarts that counter, so each new pattern opens with a complete burst.

Top module: `charge_pulse_mod`

## Requirements
- R1: Phase code 3'd1 (fast): `cc_drive_low` is 0 on every cycle, with no interruption.
- R2: Phase code 3'd2 (top-off): the pin is released for the first TOPOFF_TICKS ticks of each PERIOD_TICKS-tick period and is pulled low for the rest of the period. The defaults of 73 and 1170 give about 1/16 of the fast rate.
- R3: Phase code 3'd3 (trickle): the pin is released for the first N ticks of each period. N depends on the rate code: 2'b00 (C/2 rate) gives TRICKLE_HALF_TICKS (73), 2'b01 (1C) gives TRICKLE_ONE_TICKS (37), and 2'b10 or 2'b11 (2C) gives TRICKLE_TWO_TICKS (18).
- R4: Phase code 3'd4 (low-power): `cc_drive_low` is 0.
- R5: Phase code 3'd0 (off), and the unused codes 3'd5 to 3'd7, hold `cc_drive_low` at 1.
- R6: The period position advances by one only on a clock edge where `tick_ms` is high. It wraps from PERIOD_TICKS-1 to 0. Between ticks the output pattern holds.
- R7: On the first cycle that a new phase code is present, the period position is 0. This gives a full burst at once, and a tick in that cycle counts as the first tick of the fresh period.
- R8: While `rst_n` is low, the period counter is cleared. With phase off, the pin is pulled low.
- R9: `cc_hiz` is always the complement of `cc_drive_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| phase | input | 3 | Charge phase: 0 off, 1 fast, 2 top-off, 3 trickle, 4 low-power |
| rate | input | 2 | Charge-rate mode: 00 C/2, 01 1C, 10/11 2C |
| cc_drive_low | output | 1 | 1 pulls the charge-enable pin low and blocks current |
| cc_hiz | output | 1 | 1 releases the pin so current may flow |

## Verification
The assertions check on every cycle that:
- fast and low-power phases never pull the pin low;
- off and unused codes always pull it low;
- the period position stays below the period length;
- the position holds between ticks;
- the position is near zero just after a phase change.

Burst lengths for each rate code, top-off duty, and wrap timing under sparse ticks can only be shown by the bench. It sweeps every phase and rate code at two tick densities and predicts each cycle from a tick count of its own. It also switches phase in the middle of a period to confirm that the pattern restarts.

// File: rtl/charge_pulse_mod.sv
module charge_pulse_mod #(
  parameter int PERIOD_TICKS       = 1170,
  parameter int TOPOFF_TICKS       = 73,
  parameter int TRICKLE_HALF_TICKS = 73,
  parameter int TRICKLE_ONE_TICKS  = 37,
  parameter int TRICKLE_TWO_TICKS  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic [2:0] phase,
  input  logic [1:0] rate,
  output logic       cc_drive_low,
  output logic       cc_hiz
);
  localparam int CW = $clog2(PERIOD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);
  localparam logic [2:0] PH_OFF = 3'd0, PH_FAST = 3'd1, PH_TOP = 3'd2,
                         PH_TRK = 3'd3, PH_LP = 3'd4;

  logic [2:0]    phase_q;
  logic [CW-1:0] cnt, pos, trk_width, width;
  logic          restart, in_burst;

  assign restart = (phase != phase_q);
  assign pos     = restart ? '0 : cnt;

  always_comb begin
    case (rate)
      2'b00:   trk_width = CW'(TRICKLE_HALF_TICKS);
      2'b01:   trk_width = CW'(TRICKLE_ONE_TICKS);
      default: trk_width = CW'(TRICKLE_TWO_TICKS);
    endcase
  end

  assign width    = (phase == PH_TOP) ? CW'(TOPOFF_TICKS) : trk_width;
  assign in_burst = (pos < width);

  always_comb begin
    case (phase)
      PH_FAST, PH_LP: cc_drive_low = 1'b0;
      PH_TOP, PH_TRK: cc_drive_low = !in_burst;
      default:        cc_drive_low = 1'b1;
    endcase
  end
  assign cc_hiz = !cc_drive_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase_q <= PH_OFF;
    end else begin
      phase_q <= phase;
      if (tick_ms) cnt <= (pos == LAST) ? '0 : pos + 1'b1;
      else         cnt <= pos;
    end
  end

  p_fast_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FAST && phase_q == PH_FAST) |-> !cc_drive_low);
  p_lowpower_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LP) |-> (cc_hiz && !cc_drive_low));
  p_off_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF || phase > PH_LP) |-> cc_drive_low);
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ms && !restart) |=> $stable(cnt));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt <= 1));
  p_pin_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cc_hiz != cc_drive_low);
endmodule

// File: tb/charge_pulse_mod_tb.sv
module charge_pulse_mod_tb;
  localparam int P = 20, TOP = 5, TH = 6, T1 = 3, T2 = 2;

  logic clk = 0, rst_n = 0, tick_ms = 0;
  logic [2:0] phase = 0;
  logic [1:0] rate = 0;
  logic cc_drive_low, cc_hiz;
  int checks = 0, fails = 0, k = 0;
  bit done = 0;

  always #10 clk = ~clk;

  charge_pulse_mod #(.PERIOD_TICKS(P), .TOPOFF_TICKS(TOP), .TRICKLE_HALF_TICKS(TH),
    .TRICKLE_ONE_TICKS(T1), .TRICKLE_TWO_TICKS(T2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .phase(phase), .rate(rate),
    .cc_drive_low(cc_drive_low), .cc_hiz(cc_hiz));

  function automatic logic exp_low(input logic [2:0] ph, input logic [1:0] rt, input int kk);
    int w;
    case (rt) 2'b00: w = TH; 2'b01: w = T1; default: w = T2; endcase
    case (ph)
      3'd1, 3'd4: return 1'b0;
      3'd2: return !((kk % P) < TOP);
      3'd3: return !((kk % P) < w);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input logic exp, input string req);
    checks++;
    if (cc_drive_low !== exp || cc_hiz !== !exp) begin
      fails++;
      $display("FAIL %s phase=%0d rate=%0d k=%0d drive_low=%b hiz=%b expected drive_low=%b",
               req, phase, rate, k, cc_drive_low, cc_hiz, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] ph);
    case (ph)
      3'd1: return "R1"; 3'd2: return "R2"; 3'd3: return "R3";
      3'd4: return "R4"; default: return "R5";
    endcase
  endfunction

  // one run: new phase held for n cycles, tick every 'gap' cycles; k restarts per R7
  task automatic run(input logic [2:0] ph, input logic [1:0] rt, input int n, input int gap);
    @(negedge clk);
    phase = ph; rate = rt; k = 0;
    for (int c = 0; c < n; c++) begin
      if (c > 0) @(negedge clk);
      tick_ms = ((c % gap) == 0);
      #1 check(exp_low(ph, rt, k), (c == 0) ? "R7" : (gap > 1 ? "R6" : req_of(ph)));
      @(posedge clk);
      if (tick_ms) k++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check(1'b1, "R8");
    @(negedge clk); rst_n = 1;
    run(3'd3, 2'b00, 12, 1);
    for (int g = 1; g <= 3; g += 2)
      for (int ph = 0; ph < 8; ph++)
        for (int rt = 0; rt < 4; rt++) begin
          run(3'd0, 2'b00, 1, 1);
          run(3'(ph), 2'(rt), 45, g);
        end
    run(3'd3, 2'b01, 13, 1);
    run(3'd2, 2'b01, 30, 1);
    run(3'd3, 2'b10, 27, 2);
    run(3'd1, 2'b10, 10, 1);
    run(3'd3, 2'b00, 25, 1);
    @(negedge clk); rst_n = 0; phase = 0; tick_ms = 0;
    @(negedge clk); #1 check(1'b1, "R8");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule